// File: doc/BRIEF.md
# Chunked Interrupt ID Allocator

This block hands out contiguous ranges of message interrupt IDs and takes them back later. The ID space is split into chunks of 32 IDs, and one bit per chunk records whether the chunk is in use. IDs below 8192 are reserved and never granted, so chunk c covers IDs 8192 + 32c up to 8192 + 32c + 31. The parameter `ID_BITS` sets the width of an ID, and from it the chunk count ((1 << ID_BITS) − 8192) / 32.

An allocate request carries an ID count. The count is rounded up to whole chunks, and the block scans the chunk bitmap from chunk 0 for the lowest free run of that length. When no run is long enough, the block does not simply refuse. It grants the longest run that exists, which is the first run of that length, and it fails only when no chunk is free. A free request carries a base ID and a count. It releases every chunk of the range, reports any chunk in the range that was not in use, and rejects a range that leaves the ID space.

Requests are handled one at a time. `busy` is high from acceptance until the response. `done` pulses for one cycle when the response fields are valid, and a scan takes at most one cycle per chunk.

Top module: `chunk_id_allocator`

## Requirements
- R1: After reset, `busy` and `done` are low and every chunk is free, so the first grant starts at ID 8192.
- R2: A request is accepted only when `req_valid` is high and `busy` is low. A request presented while `busy` is high has no effect on the bitmap.
- R3: An allocate request asks for ceil(count/32) chunks. A count of 0 asks for no chunks and fails with `rsp_ok`=0.
- R4: When a free run of the requested length exists, the grant is the lowest-indexed such run. It reports `rsp_base` = 8192 + 32·first_chunk and `rsp_count` = 32·chunks.
- R5: When no run is long enough, the grant is the longest free run, taking the lowest-indexed run of that length, and `rsp_count` reflects the shorter length.
- R6: When no chunk is free, an allocate fails: `rsp_ok`=0 and `rsp_base`=`rsp_count`=0.
- R7: Granted chunks are marked used, so no later grant overlaps them until they are freed.
- R8: A free request (`req_free`=1) releases the ceil(count/32) chunks that start at chunk (base − 8192) >> 5 and answers `rsp_ok`=1. A free count of 0 changes nothing.
- R9: If any chunk in a valid free range was already free, `rsp_bad_free`=1. The other chunks of the range are still released.
- R10: A free whose base is below 8192, or whose range extends past the last chunk, answers `rsp_range_err`=1 and `rsp_ok`=0 and leaves the bitmap unchanged.
- R11: `done` is a one-cycle pulse. The response fields stay unchanged until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_free | input | 1 | 1 = free request, 0 = allocate request |
| req_base | input | ID_BITS | First ID of the range to free |
| req_count | input | ID_BITS | Number of IDs to allocate or free |
| busy | output | 1 | Request in progress; new requests are not accepted |
| done | output | 1 | One-cycle pulse: response fields valid |
| rsp_ok | output | 1 | Allocate granted, or free accepted |
| rsp_base | output | ID_BITS | First granted ID (allocate), otherwise 0 |
| rsp_count | output | ID_BITS | Number of granted IDs (allocate), otherwise 0 |
| rsp_bad_free | output | 1 | A freed chunk was not in use |
| rsp_range_err | output | 1 | Free range outside the ID space; nothing changed |

## Verification
The directed cases cover the following:
- A full-length grant, tested from an empty map and again after a hole has been freed, so the bench can confirm the lowest-run choice.
- Partial grants from a full map that has holes of different sizes. These show that the block takes the longest run and not the first free run.
- Exhaustion, a single free chunk at the very end of the space, a double free, and ranges that cross either edge of the ID space.
- A request held on the inputs while the block is busy, which shows whether it leaked into the bitmap.

Seeded random mixes of allocates of many sizes and frees of both granted and arbitrary ranges fragment the map in ways the directed cases do not. Every response is compared against a model that performs the repeated shrink-and-search literally.

// File: rtl/chunk_alloc_pkg.sv
// Package: shared constants and state encoding for the chunked ID allocator.
// Assumes: IDs below RESERVED_IDS are never handed out; chunk size is 2**CHUNK_SHIFT.
package chunk_alloc_pkg;

    localparam int RESERVED_IDS = 8192;
    localparam int CHUNK_SHIFT  = 5;
    localparam int CHUNK_IDS    = 1 << CHUNK_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MARK,
        ST_FREE,
        ST_RESP
    } alloc_state_e;

endpackage

// File: rtl/chunk_bitmap.sv
// Module: one bit of use state per chunk, with one read and one write port.
// Assumes: at most one chunk is written per cycle; indices at or above N_CHUNKS are never written.
module chunk_bitmap #(
    parameter int N_CHUNKS = 256,
    parameter int IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_used,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val
);

    logic [N_CHUNKS-1:0] used_q;

    // Combinational read of the addressed chunk.
    always_comb begin
        rd_used = 1'b0;
        if (int'(rd_idx) < N_CHUNKS) begin
            rd_used = used_q[rd_idx];
        end
    end

    // Clear the map on reset; otherwise update one chunk per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (wr_en && (int'(wr_idx) < N_CHUNKS)) begin
            used_q[wr_idx] <= wr_val;
        end
    end

endmodule

// File: rtl/run_tracker.sv
// Module: follows free runs while chunks are presented in ascending order.
//   It flags a run that reaches the wanted length and keeps the first run of
//   the greatest length seen so far (the partial-grant candidate).
// Assumes: want_len >= 1; clr is pulsed before the first step of a scan.
module run_tracker #(
    parameter int IDX_W = 8,
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             slot_free,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic [LEN_W-1:0] want_len,
    output logic             hit,
    output logic [IDX_W-1:0] hit_start,
    output logic [LEN_W-1:0] best_len_nxt,
    output logic [IDX_W-1:0] best_start_nxt
);

    logic [IDX_W-1:0] cur_start_q, cur_start_n;
    logic [LEN_W-1:0] cur_len_q, cur_len_n;
    logic [IDX_W-1:0] best_start_q;
    logic [LEN_W-1:0] best_len_q;

    // Extend or break the current run using the slot presented this cycle.
    always_comb begin
        cur_start_n = cur_start_q;
        cur_len_n   = '0;
        if (slot_free) begin
            cur_start_n = (cur_len_q == '0) ? slot_idx : cur_start_q;
            cur_len_n   = cur_len_q + LEN_W'(1);
        end
    end

    // Raise hit on a full-length run; a best run is replaced only by a strictly longer one.
    always_comb begin
        hit            = step && slot_free && (cur_len_n >= want_len);
        hit_start      = cur_start_n;
        best_len_nxt   = best_len_q;
        best_start_nxt = best_start_q;
        if (cur_len_n > best_len_q) begin
            best_len_nxt   = cur_len_n;
            best_start_nxt = cur_start_n;
        end
    end

    // Hold the run state between steps; clear it at the start of a scan.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cur_start_q  <= '0;
            cur_len_q    <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
        end else if (step) begin
            cur_start_q  <= cur_start_n;
            cur_len_q    <= cur_len_n;
            best_start_q <= best_start_nxt;
            best_len_q   <= best_len_nxt;
        end
    end

endmodule

// File: rtl/free_range_decoder.sv
// Module: turns an ID base and count into a first chunk and a chunk count,
//   and flags ranges that start in the reserved area or pass the last chunk.
// Assumes: purely combinational; the chunk count is also used for allocate sizing.
module free_range_decoder
    import chunk_alloc_pkg::*;
#(
    parameter int ID_BITS  = 14,
    parameter int N_CHUNKS = 256,
    parameter int IDX_W    = 9,
    parameter int LEN_W    = 10
) (
    input  logic [ID_BITS-1:0] base,
    input  logic [ID_BITS-1:0] count,
    output logic [IDX_W-1:0]   first_chunk,
    output logic [LEN_W-1:0]   n_chunks,
    output logic               range_bad
);

    logic [ID_BITS-1:0] offs;
    logic [ID_BITS:0]   rounded;
    logic [LEN_W:0]     end_chunk;

    // Chunk arithmetic: offset from the reserved area, round the count up, compare the end.
    always_comb begin
        offs        = base - ID_BITS'(RESERVED_IDS);
        first_chunk = IDX_W'(offs >> CHUNK_SHIFT);
        rounded     = {1'b0, count} + (ID_BITS + 1)'(CHUNK_IDS - 1);
        n_chunks    = LEN_W'(rounded >> CHUNK_SHIFT);
        end_chunk   = (LEN_W + 1)'(first_chunk) + (LEN_W + 1)'(n_chunks);
        range_bad   = (int'(base) < RESERVED_IDS) || (int'(end_chunk) > N_CHUNKS);
    end

endmodule

// File: rtl/chunk_id_allocator.sv
// Module: top of the chunked interrupt ID allocator.
//   Allocate: scan chunks 0..N-1 one per cycle, grant the first full-length run
//   or the first longest run, then mark the granted chunks one per cycle.
//   Free: walk the decoded range one chunk per cycle, clearing used chunks and
//   noting chunks that were already free.
// Assumes: ID_BITS >= 14; one request at a time, accepted only while idle.
module chunk_id_allocator
    import chunk_alloc_pkg::*;
#(
    parameter int ID_BITS = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_free,
    input  logic [ID_BITS-1:0] req_base,
    input  logic [ID_BITS-1:0] req_count,
    output logic               busy,
    output logic               done,
    output logic               rsp_ok,
    output logic [ID_BITS-1:0] rsp_base,
    output logic [ID_BITS-1:0] rsp_count,
    output logic               rsp_bad_free,
    output logic               rsp_range_err
);

    localparam int N_CHUNKS = ((1 << ID_BITS) - RESERVED_IDS) >> CHUNK_SHIFT;
    localparam int IDX_W    = ID_BITS - CHUNK_SHIFT;
    localparam int LEN_W    = IDX_W + 1;

    alloc_state_e     state_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] want_q;
    logic [LEN_W-1:0] left_q;
    logic             bad_q;

    logic             accept;
    logic             rd_used;
    logic             wr_en;
    logic             wr_val;
    logic             last_idx;
    logic             hit;
    logic [IDX_W-1:0] hit_start;
    logic [LEN_W-1:0] best_len_nxt;
    logic [IDX_W-1:0] best_start_nxt;
    logic [IDX_W-1:0] dec_first;
    logic [LEN_W-1:0] dec_chunks;
    logic             dec_bad;

    // First ID of a chunk.
    function automatic logic [ID_BITS-1:0] id_of(input logic [IDX_W-1:0] c);
        return ID_BITS'(RESERVED_IDS) + (ID_BITS'(c) << CHUNK_SHIFT);
    endfunction

    // Number of IDs in a run of chunks.
    function automatic logic [ID_BITS-1:0] ids_in(input logic [LEN_W-1:0] n);
        return ID_BITS'(n) << CHUNK_SHIFT;
    endfunction

    chunk_bitmap #(
        .N_CHUNKS (N_CHUNKS),
        .IDX_W    (IDX_W)
    ) i_bitmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx_q),
        .rd_used (rd_used),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_val  (wr_val)
    );

    run_tracker #(
        .IDX_W (IDX_W),
        .LEN_W (LEN_W)
    ) i_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr            (accept),
        .step           (state_q == ST_SCAN),
        .slot_free      (!rd_used),
        .slot_idx       (idx_q),
        .want_len       (want_q),
        .hit            (hit),
        .hit_start      (hit_start),
        .best_len_nxt   (best_len_nxt),
        .best_start_nxt (best_start_nxt)
    );

    free_range_decoder #(
        .ID_BITS  (ID_BITS),
        .N_CHUNKS (N_CHUNKS),
        .IDX_W    (IDX_W),
        .LEN_W    (LEN_W)
    ) i_decoder (
        .base        (req_base),
        .count       (req_count),
        .first_chunk (dec_first),
        .n_chunks    (dec_chunks),
        .range_bad   (dec_bad)
    );

    // Handshake, status outputs and bitmap write controls.
    always_comb begin
        accept   = req_valid && (state_q == ST_IDLE);
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_RESP);
        last_idx = (idx_q == IDX_W'(N_CHUNKS - 1));
        wr_en    = (state_q == ST_MARK) || ((state_q == ST_FREE) && rd_used);
        wr_val   = (state_q == ST_MARK);
    end

    // Request sequencing: accept, scan, mark or free walk, then respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            idx_q         <= '0;
            want_q        <= '0;
            left_q        <= '0;
            bad_q         <= 1'b0;
            rsp_ok        <= 1'b0;
            rsp_base      <= '0;
            rsp_count     <= '0;
            rsp_bad_free  <= 1'b0;
            rsp_range_err <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        rsp_ok        <= 1'b0;
                        rsp_base      <= '0;
                        rsp_count     <= '0;
                        rsp_bad_free  <= 1'b0;
                        rsp_range_err <= 1'b0;
                        bad_q         <= 1'b0;
                        if (req_free) begin
                            if (dec_bad) begin
                                rsp_range_err <= 1'b1;
                                state_q       <= ST_RESP;
                            end else if (dec_chunks == '0) begin
                                rsp_ok  <= 1'b1;
                                state_q <= ST_RESP;
                            end else begin
                                idx_q   <= dec_first;
                                left_q  <= dec_chunks;
                                state_q <= ST_FREE;
                            end
                        end else begin
                            if (dec_chunks == '0) begin
                                state_q <= ST_RESP;
                            end else begin
                                want_q  <= dec_chunks;
                                idx_q   <= '0;
                                state_q <= ST_SCAN;
                            end
                        end
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        idx_q     <= hit_start;
                        left_q    <= want_q;
                        rsp_base  <= id_of(hit_start);
                        rsp_count <= ids_in(want_q);
                        state_q   <= ST_MARK;
                    end else if (last_idx) begin
                        if (best_len_nxt == '0) begin
                            state_q <= ST_RESP;
                        end else begin
                            idx_q     <= best_start_nxt;
                            left_q    <= best_len_nxt;
                            rsp_base  <= id_of(best_start_nxt);
                            rsp_count <= ids_in(best_len_nxt);
                            state_q   <= ST_MARK;
                        end
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_MARK: begin
                    idx_q  <= idx_q + IDX_W'(1);
                    left_q <= left_q - LEN_W'(1);
                    if (left_q == LEN_W'(1)) begin
                        rsp_ok  <= 1'b1;
                        state_q <= ST_RESP;
                    end
                end
                ST_FREE: begin
                    idx_q  <= idx_q + IDX_W'(1);
                    left_q <= left_q - LEN_W'(1);
                    if (!rd_used) begin
                        bad_q <= 1'b1;
                    end
                    if (left_q == LEN_W'(1)) begin
                        rsp_ok       <= 1'b1;
                        rsp_bad_free <= bad_q || !rd_used;
                        state_q      <= ST_RESP;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/chunk_id_allocator_chk.sv
// Module: protocol and response-shape checks for chunk_id_allocator.
// Assumes: bound to every instance of the top; it observes ports only.
module chunk_id_allocator_chk #(
    parameter int ID_BITS = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_free,
    input logic [ID_BITS-1:0] req_count,
    input logic               busy,
    input logic               done,
    input logic               rsp_ok,
    input logic [ID_BITS-1:0] rsp_base,
    input logic [ID_BITS-1:0] rsp_count,
    input logic               rsp_bad_free,
    input logic               rsp_range_err
);

    logic           op_free_q;
    logic [ID_BITS:0] ask_ids_q;

    // Record the kind and rounded size of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_free_q <= 1'b0;
            ask_ids_q <= '0;
        end else if (req_valid && !busy) begin
            op_free_q <= req_free;
            ask_ids_q <= ({1'b0, req_count} + (ID_BITS + 1)'(31)) & ~(ID_BITS + 1)'(31);
        end
    end

    // R2: an accepted request makes the block busy in the next cycle.
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R11: done lasts exactly one cycle.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: while idle with no request, the response fields do not move.
    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> ($stable(rsp_ok) && $stable(rsp_base) &&
                                   $stable(rsp_count) && $stable(rsp_bad_free) &&
                                   $stable(rsp_range_err)));

    // R4: a grant is chunk aligned, above the reserved area and non-empty.
    p_grant_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_free_q && rsp_ok) |->
            ((rsp_base[4:0] == 5'd0) && (int'(rsp_base) >= 8192) &&
             (rsp_count[4:0] == 5'd0) && (rsp_count != '0)));

    // R5: a grant never exceeds the rounded-up request.
    p_grant_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_free_q && rsp_ok) |-> ((ID_BITS + 1)'(rsp_count) <= ask_ids_q));

    // R6: a failed allocate reports an empty range.
    p_fail_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_free_q && !rsp_ok) |-> ((rsp_count == '0) && (rsp_base == '0)));

    // R10: a range error is neither a success nor a bad free.
    p_range_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_range_err) |-> (!rsp_ok && !rsp_bad_free && op_free_q));

endmodule

bind chunk_id_allocator chunk_id_allocator_chk #(.ID_BITS(ID_BITS)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_free      (req_free),
    .req_count     (req_count),
    .busy          (busy),
    .done          (done),
    .rsp_ok        (rsp_ok),
    .rsp_base      (rsp_base),
    .rsp_count     (rsp_count),
    .rsp_bad_free  (rsp_bad_free),
    .rsp_range_err (rsp_range_err)
);

// File: tb/test_chunk_id_allocator.sv
// Bench: directed corner cases plus seeded random traffic, compared with a
// bench-side model that performs the shrink-and-search literally.
module test_chunk_id_allocator;

    localparam int ID_BITS = 14;
    localparam int NCH     = ((1 << ID_BITS) - 8192) >> 5;
    localparam int CLK_P   = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_free = 1'b0;
    logic [ID_BITS-1:0] req_base = '0;
    logic [ID_BITS-1:0] req_count = '0;
    logic               busy, done, rsp_ok, rsp_bad_free, rsp_range_err;
    logic [ID_BITS-1:0] rsp_base, rsp_count;

    int errors = 0;
    int checks = 0;
    bit mdl [NCH];
    int got_ok, got_base, got_count, got_bad, got_rerr;

    always #(CLK_P / 2) clk = ~clk;

    chunk_id_allocator #(.ID_BITS(ID_BITS)) i_chunk_id_allocator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
        .req_base(req_base), .req_count(req_count), .busy(busy), .done(done),
        .rsp_ok(rsp_ok), .rsp_base(rsp_base), .rsp_count(rsp_count),
        .rsp_bad_free(rsp_bad_free), .rsp_range_err(rsp_range_err)
    );

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model allocate: repeat the lowest-run search, shrinking the length on failure.
    function automatic void mdl_alloc(input int cnt, output int ok, output int b, output int c);
        int k = (cnt + 31) / 32;
        ok = 0; b = 0; c = 0;
        while (k > 0 && ok == 0) begin
            for (int s = 0; s + k <= NCH && ok == 0; s++) begin
                bit fits = 1'b1;
                for (int j = 0; j < k; j++) if (mdl[s + j]) fits = 1'b0;
                if (fits) begin
                    for (int j = 0; j < k; j++) mdl[s + j] = 1'b1;
                    ok = 1; b = s * 32 + 8192; c = k * 32;
                end
            end
            if (ok == 0) k--;
        end
    endfunction

    // Model free: range check first, then clear chunks and note already-free ones.
    function automatic void mdl_free(input int base, input int cnt, output int ok,
                                     output int bad, output int rerr);
        int n = (cnt + 31) / 32;
        int f = (base - 8192) >> 5;
        ok = 0; bad = 0; rerr = 0;
        if (base < 8192 || f + n > NCH) begin
            rerr = 1;
        end else begin
            ok = 1;
            for (int j = 0; j < n; j++) begin
                if (mdl[f + j]) mdl[f + j] = 1'b0;
                else bad = 1;
            end
        end
    endfunction

    // Drive one request; optionally keep a conflicting free on the inputs while busy.
    task automatic run_op(input bit op_free, input int base, input int cnt, input bit hold);
        int waitc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_free = op_free;
        req_base = ID_BITS'(base); req_count = ID_BITS'(cnt);
        @(negedge clk);
        if (hold) begin
            req_free = 1'b1; req_base = ID_BITS'(8192); req_count = ID_BITS'(32);
        end else begin
            req_valid = 1'b0;
        end
        while (!done && waitc < 4000) begin
            @(negedge clk);
            waitc++;
        end
        req_valid = 1'b0;
        if (!done) begin
            errors++; checks++;
            $display("FAIL R11 watchdog: actual=no done expected=done");
        end
        got_ok = int'(rsp_ok); got_base = int'(rsp_base); got_count = int'(rsp_count);
        got_bad = int'(rsp_bad_free); got_rerr = int'(rsp_range_err);
        @(negedge clk);
        check_int("R11", "done pulse width", int'(done), 0);
        check_int("R11", "held count", int'(rsp_count), got_count);
    endtask

    task automatic do_alloc(input string req, input int cnt, input bit hold);
        int eok, eb, ec;
        mdl_alloc(cnt, eok, eb, ec);
        run_op(1'b0, 0, cnt, hold);
        check_int(req, "alloc ok", got_ok, eok);
        check_int(req, "alloc base", got_base, eb);
        check_int(req, "alloc count", got_count, ec);
    endtask

    task automatic do_free(input string req, input int base, input int cnt);
        int eok, ebad, err;
        mdl_free(base, cnt, eok, ebad, err);
        run_op(1'b1, base, cnt, 1'b0);
        check_int(req, "free ok", got_ok, eok);
        check_int(req, "free bad", got_bad, ebad);
        check_int(req, "free range err", got_rerr, err);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int gb [64];
        int gc [64];
        int ng = 0;
        void'($urandom(32'd4711));
        for (int i = 0; i < NCH; i++) mdl[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1", "busy after reset", int'(busy), 0);
        check_int("R1", "done after reset", int'(done), 0);

        do_alloc("R1", 1, 1'b0);
        check_int("R4", "first grant base", got_base, 8192);
        do_alloc("R3", 33, 1'b0);
        check_int("R3", "33 ids rounded", got_count, 64);
        do_alloc("R3", 0, 1'b0);
        do_free("R8", 8192, 32);
        do_alloc("R7", 20, 1'b0);
        check_int("R4", "hole reused", got_base, 8192);
        do_free("R8", 8224, 64);
        do_free("R9", 8224, 64);
        do_free("R10", 8000, 32);
        do_free("R10", 8192 + 255 * 32, 64);
        do_alloc("R2", 1, 1'b1);
        do_alloc("R2", 1, 1'b0);
        do_free("R8", 8192, 0);

        do_free("R9", 8192, 8192);
        do_alloc("R4", 8192, 1'b0);
        do_free("R8", 8192 + 320, 96);
        do_free("R8", 8192 + 3200, 160);
        do_alloc("R5", 320, 1'b0);
        check_int("R5", "partial base", got_base, 8192 + 3200);
        do_alloc("R5", 100, 1'b0);
        check_int("R5", "partial count", got_count, 96);
        do_alloc("R6", 1, 1'b0);
        do_free("R8", 8192 + 255 * 32, 32);
        do_alloc("R5", 64, 1'b0);
        check_int("R5", "last chunk base", got_base, 16352);

        do_free("R9", 8192, 8192);
        for (int i = 0; i < 150; i++) begin
            int r = int'($urandom % 10);
            if (r < 5 || ng == 0) begin
                do_alloc("R4", 1 + int'($urandom % 600), 1'b0);
                if (got_ok != 0 && ng < 64) begin
                    gb[ng] = got_base; gc[ng] = got_count; ng++;
                end
            end else if (r < 9) begin
                int j = int'($urandom % ng);
                do_free("R8", gb[j], gc[j]);
                ng--; gb[j] = gb[ng]; gc[j] = gc[ng];
            end else begin
                do_free("R10", 8000 + int'($urandom % 8500), int'($urandom % 300));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule